// File: doc/BRIEF.md
# Strobed Asynchronous Character Retimer

This block sits behind an FSK demodulator and takes its raw 1200-baud asynchronous bit stream, mark being logic 1. It finds the falling edge that opens each start bit. From that edge it samples the eight data bits at their centres and keeps them in a buffer. A host with no UART then collects the character one bit at a time from a single data pin. The host paces the transfer with slow strobe pulses that software generates. An active-low interrupt tells the host that a character is waiting.

When the strobe input rests low, retiming is enabled. At the end of each character the interrupt falls and the first bit appears on the data pin. Each later strobe pulse moves the next bit onto the pin. After the eighth pulse the pin returns to the raw stream. When the strobe input is held high, the block is transparent: the raw stream reaches the data pin and the interrupt stays released. The raw input and the strobe input are both asynchronous and pass through synchronizers first. The bit period is a parameter. Its default of 2983 ticks suits a 3.579545 MHz clock.

Top module: `strobed_char_retimer`

## Requirements
- R1: After reset, irqN is high (released) and dataOut carries the raw input stream.
- R2: A 1-to-0 transition of rawIn, seen while hunting, starts a character. Data bits are sampled 1.5 bit periods after that edge and then once per bit period. Eight bits are taken, and the first one received is bit 0 (least significant).
- R3: When the eighth bit has been taken and strobeIn is low, irqN goes low and dataOut presents bit 0 of the character.
- R4: irqN returns high the first time strobeIn goes high after it was asserted.
- R5: The falling strobe edges that end strobe pulses 1 to 7 put character bits 1 to 7 on dataOut, in that order.
- R6: The falling edge that ends the eighth strobe pulse reconnects dataOut to the raw stream.
- R7: While strobeIn is held high, no character is offered: irqN stays high and dataOut follows rawIn.
- R8: A character completed while an earlier one is still being collected is discarded. The earlier one is delivered intact, and no further interrupt follows.
- R9: A new start edge is accepted only from the centre of the stop bit onward, so space bits inside a character never restart it. An alternating mark/space preamble (start 0, then 1,0,1,0,1,0,1,0, then stop 1) is delivered as characters of value 0x55.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock; one bit period is BIT_TICKS cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| rawIn | input | 1 | Raw demodulated bit stream, asynchronous, 1 = mark |
| strobeIn | input | 1 | Host strobe; held high disables retiming |
| dataOut | output | 1 | Buffered character bit, or the raw stream when no character is offered |
| irqN | output | 1 | Active-low character-ready request |

## Verification
The assertions assume that strobeIn makes a clean rise before each fall, as a host pulse train does. They also assume that the host finishes its eight pulses well inside one character time and that rawIn holds each bit for a full period. The bench shortens the bit period to 40 clock cycles and holds every strobe level for 6 cycles, so each synchronized edge is distinct. The host reading is placed between characters, or run alongside a continuous preamble with enough slack. Random character values are drawn with a fixed seed. Directed cases cover the preamble, the transparent mode and the discarded second character.

// File: rtl/retimer_pkg.sv
package retimer_pkg;
  typedef enum logic [1:0] {RX_HUNT, RX_DATA, RX_STOP} rxState_t;
  typedef enum logic {TX_PASS, TX_SEND} txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleEn;   // take one data bit into the receive shift register
    logic loadHold;   // move the received character into the hold register
    logic shiftHold;  // present the next held bit
    logic passThru;   // output carries the raw stream
  } dpCtl_t;
endpackage

// File: rtl/retimer_sync.sv
module retimer_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= RESET_VAL;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/retimer_ctrl.sv
module retimer_ctrl
  import retimer_pkg::*;
#(
  parameter int BIT_TICKS = 2983,
  parameter int DATA_BITS = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   rawSync,
  input  logic   strobeSync,
  output dpCtl_t ctl,
  output logic   irqAct
);
  localparam int FIRST_WAIT = BIT_TICKS + BIT_TICKS / 2;
  localparam int CNT_W = $clog2(FIRST_WAIT + 1);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] FIRST_LOAD = CNT_W'(FIRST_WAIT - 1);
  localparam logic [CNT_W-1:0] BIT_LOAD = CNT_W'(BIT_TICKS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rxState_t rxState;
  txState_t txState;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] fallCnt;
  logic rawPrev, strobePrev, charRdyQ, irqQ;
  logic sampleTick, startEdge, strobeRise, strobeFall;

  assign startEdge  = rawPrev && !rawSync;
  assign strobeRise = !strobePrev && strobeSync;
  assign strobeFall = strobePrev && !strobeSync;
  assign sampleTick = (rxState == RX_DATA) && (tickCnt == '0);

  // receive timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= RX_HUNT;
      tickCnt  <= '0;
      bitIdx   <= '0;
      rawPrev  <= 1'b1;
      charRdyQ <= 1'b0;
    end else begin
      rawPrev  <= rawSync;
      charRdyQ <= sampleTick && (bitIdx == LAST_IDX);
      unique case (rxState)
        RX_HUNT: if (startEdge) begin
          rxState <= RX_DATA;
          tickCnt <= FIRST_LOAD;
          bitIdx  <= '0;
        end
        RX_DATA: if (tickCnt == '0) begin
          tickCnt <= BIT_LOAD;
          if (bitIdx == LAST_IDX) rxState <= RX_STOP;
          else bitIdx <= bitIdx + 1'b1;
        end else begin
          tickCnt <= tickCnt - 1'b1;
        end
        RX_STOP: if (tickCnt == '0) rxState <= RX_HUNT;
                 else tickCnt <= tickCnt - 1'b1;
        default: rxState <= RX_HUNT;
      endcase
    end
  end

  // host transfer
  always_comb begin
    ctl.sampleEn  = sampleTick;
    ctl.loadHold  = (txState == TX_PASS) && charRdyQ && !strobeSync;
    ctl.shiftHold = (txState == TX_SEND) && strobeFall && (fallCnt != LAST_IDX);
    ctl.passThru  = (txState == TX_PASS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState    <= TX_PASS;
      fallCnt    <= '0;
      irqQ       <= 1'b0;
      strobePrev <= 1'b1;
    end else begin
      strobePrev <= strobeSync;
      unique case (txState)
        TX_PASS: if (ctl.loadHold) begin
          txState <= TX_SEND;
          fallCnt <= '0;
          irqQ    <= 1'b1;
        end
        TX_SEND: begin
          if (strobeRise) irqQ <= 1'b0;
          if (strobeFall) begin
            if (fallCnt == LAST_IDX) begin
              txState <= TX_PASS;
              irqQ    <= 1'b0;
            end else begin
              fallCnt <= fallCnt + 1'b1;
            end
          end
        end
        default: txState <= TX_PASS;
      endcase
    end
  end

  assign irqAct = irqQ;

  AST_CHAR_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    charRdyQ |-> $past(ctl.sampleEn)) else $error("char ready without sample"); // R2
  AST_IRQ_NEEDS_LOW_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> !$past(strobeSync)) else $error("irq with strobe high"); // R3
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && strobeRise) |=> !irqQ) else $error("irq not released"); // R4
  AST_RETURN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_SEND && strobeFall && fallCnt == LAST_IDX) |=> (txState == TX_PASS && !irqQ))
    else $error("no return to pass-through"); // R6
  AST_DISABLED_STAYS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_PASS && strobeSync) |=> txState == TX_PASS) else $error("offer while disabled"); // R7
  AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_SEND && charRdyQ && !strobeFall) |=> (txState == TX_SEND && $stable(fallCnt)))
    else $error("busy transfer disturbed"); // R8
  AST_NO_RESTART_IN_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_DATA && tickCnt != '0) |=> (rxState == RX_DATA && tickCnt == $past(tickCnt) - 1'b1))
    else $error("character restarted"); // R9
endmodule

// File: rtl/retimer_datapath.sv
module retimer_datapath
  import retimer_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   rawSync,
  input  dpCtl_t ctl,
  output logic   dataOut
);
  logic [DATA_BITS-1:0] rxShift;
  logic [DATA_BITS-1:0] holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '1;
      holdReg <= '1;
    end else begin
      if (ctl.sampleEn) rxShift <= {rawSync, rxShift[DATA_BITS-1:1]};
      if (ctl.loadHold)       holdReg <= rxShift;
      else if (ctl.shiftHold) holdReg <= {1'b1, holdReg[DATA_BITS-1:1]};
    end
  end

  assign dataOut = ctl.passThru ? rawSync : holdReg[0];

  AST_FIRST_BIT_SHOWN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadHold |=> (dataOut == $past(rxShift[0]))) else $error("bit 0 not presented"); // R3
  AST_NEXT_BIT_SHOWN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftHold |=> (dataOut == $past(holdReg[1]))) else $error("next bit not presented"); // R5
endmodule

// File: rtl/strobed_char_retimer.sv
module strobed_char_retimer
  import retimer_pkg::*;
#(
  parameter int BIT_TICKS = 2983,
  parameter int DATA_BITS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic strobeIn,
  output logic dataOut,
  output logic irqN
);
  logic rawSync, strobeSync, irqAct;
  dpCtl_t ctl;

  retimer_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) rawSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(rawSync));
  retimer_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) strobeSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(strobeIn), .syncOut(strobeSync));

  retimer_ctrl #(.BIT_TICKS(BIT_TICKS), .DATA_BITS(DATA_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .rawSync(rawSync), .strobeSync(strobeSync),
    .ctl(ctl), .irqAct(irqAct));

  retimer_datapath #(.DATA_BITS(DATA_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .rawSync(rawSync), .ctl(ctl), .dataOut(dataOut));

  assign irqN = ~irqAct;

  AST_RESET_RELEASED: assert property (@(posedge clk) $rose(rstN) |-> irqN)
    else $error("irq active out of reset"); // R1
endmodule

// File: tb/strobed_char_retimer_tb_top.sv
`timescale 1ns/1ps
module strobed_char_retimer_tb_top;
  localparam int BIT = 40;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawIn = 1'b1;
  logic strobeIn = 1'b0;
  logic dataOut, irqN;
  int nChecks = 0;
  int nFails = 0;
  bit chkPass = 1'b0;
  bit sawIrq = 1'b0;

  always #5 clk = ~clk;

  strobed_char_retimer #(.BIT_TICKS(BIT)) dut_i (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .strobeIn(strobeIn),
    .dataOut(dataOut), .irqN(irqN));

  always @(negedge clk) if (rstN && !irqN) sawIrq = 1'b1;

  function automatic logic [9:0] frameOf(input logic [7:0] c);
    return {1'b1, c, 1'b0};  // sent LSB first: start, data0..7, stop
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkByte(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendChar(input logic [7:0] c);
    logic [9:0] f = frameOf(c);
    for (int b = 0; b < 10; b++) begin
      @(negedge clk) rawIn = f[b];
      repeat (BIT / 2) @(negedge clk);
      if (chkPass) check("R7 pass-through", dataOut, f[b]);
      repeat (BIT - BIT / 2 - 1) @(negedge clk);
    end
    @(negedge clk) rawIn = 1'b1;
  endtask

  task automatic readChar(input logic [7:0] exp, input string tag);
    logic [7:0] got = '0;
    int w = 0;
    while (irqN && w < BIT * 14) begin @(negedge clk); w++; end
    check("R3 irq asserted", irqN, 1'b0);
    repeat (2) @(negedge clk);
    got[0] = dataOut;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk) strobeIn = 1'b1;
      repeat (HALF) @(negedge clk);
      if (k == 1) check("R4 irq released", irqN, 1'b1);
      strobeIn = 1'b0;
      repeat (HALF) @(negedge clk);
      if (k < 8) got[k] = dataOut;
    end
    checkByte(tag, got, exp);
    // raw idles at mark; held bit 7 would be shown otherwise
    check("R6 back to raw", dataOut, rawIn);
  endtask

  initial begin : main
    logic [7:0] c, c2;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1 irq after reset", irqN, 1'b1);
    check("R1 data after reset", dataOut, 1'b1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R7: transparent mode
    strobeIn = 1'b1;
    repeat (6) @(negedge clk);
    sawIrq = 1'b0;
    chkPass = 1'b1;
    sendChar(8'hA3);
    sendChar(8'h5C);
    chkPass = 1'b0;
    repeat (BIT) @(negedge clk);
    check("R7 no irq when disabled", sawIrq, 1'b0);
    strobeIn = 1'b0;
    repeat (6) @(negedge clk);

    // R2 R5: directed bit patterns, LSB first
    sendChar(8'h01); readChar(8'h01, "R2 lsb first");
    sendChar(8'h80); readChar(8'h80, "R5 msb last");
    sendChar(8'h00); readChar(8'h00, "R5 all space");
    sendChar(8'hFF); readChar(8'hFF, "R5 all mark");

    // random characters
    for (int i = 0; i < 16; i++) begin
      c = 8'($urandom);
      sendChar(c);
      readChar(c, "R2 R5 random char");
    end

    // R9: continuous alternating preamble, host reads alongside
    fork
      begin
        for (int i = 0; i < 4; i++) sendChar(8'h55);
      end
      begin
        for (int i = 0; i < 4; i++) readChar(8'h55, "R9 preamble char");
      end
    join
    repeat (2 * BIT) @(negedge clk);

    // R8: second character arrives while the first is pending
    c  = 8'($urandom);
    c2 = ~c;
    sendChar(c);
    repeat (BIT) @(negedge clk);
    check("R8 first pending", irqN, 1'b0);
    sendChar(c2);
    readChar(c, "R8 first kept");
    sawIrq = 1'b0;
    repeat (3 * BIT) @(negedge clk);
    check("R8 second dropped", sawIrq, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule